// File: doc/BRIEF.md
# LLC half-bridge soft-start sequencer

This block brings a time-shift controlled resonant half-bridge from rest to regulation. When the start command goes high, it sends one safe-start pulse pair. The high-side gate enable comes first, with a programmed on-time. A dead time follows. The low-side gate enable comes next, with a length equal to the programmed first time shift. A second dead time ends the pair. The first time shift then seeds a soft-start ramp. The ramp raises the time-shift output by a selectable step once per fixed interval until the output reaches the target supplied from the regulation loop. From then on the output tracks that target. All times are counted in clock ticks, where one tick is 16.67 ns at the nominal 60 MHz clock.

A capacitive-mode warning during the ramp or during regulation starts a soft recovery. The time shift is cut by a programmed decrement and the ramp starts again from the reduced value. The block faults instead if the cut would take the time shift to its floor, or if the warning count reaches a programmed limit. The fault holds until the start command is released. Dropping the start command returns the block to idle from any state, and idle clears the warning count.

The states are IDLE, HS_ON (high-side pulse), DEAD_A (first dead time), LS_ON (low-side pulse), DEAD_B (second dead time), RAMP (soft-start), RUN (regulation) and FAULT. The transitions are:
- start: IDLE to HS_ON.
- timer expiry: HS_ON to DEAD_A to LS_ON to DEAD_B to RAMP.
- target reached: RAMP to RUN.
- recover: RAMP or RUN to RAMP, on a warning that does not fault.
- trip: RAMP or RUN to FAULT, on a warning that does fault.
- abort: any state to IDLE, when start is low.

The configuration codes are expected to stay stable while start is high.

Top module: `llc_ss_seq`

## Requirements
- R1: After reset, ts_o is 0 and gate_hs_o, gate_ls_o, done_o and fault_o are all low.
- R2: The high-side enable is high for exactly T_on cycles, starting the cycle after start is first sampled high. T_on is 8+4c for an on-time code c below 9, and 40+8(c-8) otherwise.
- R3: Each pulse is followed by a dead time of 16+4d cycles, where d is the dead-time code. During a dead time both enables are low, and the two enables are never high together.
- R4: The low-side enable is high for exactly T_fs cycles. T_fs is 10+2c for a first-shift code c below 9, and 26+4(c-8) otherwise. ts_o equals T_fs from the first high-side cycle until the ramp takes its first step.
- R5: In RAMP, ts_o rises by (step code + 1) once every STEP_INTERVAL cycles. The first step comes STEP_INTERVAL cycles after RAMP is entered, and no step takes ts_o past the target.
- R6: done_o rises one cycle after ts_o first equals or exceeds the target, and ts_o equals the target from that cycle on. This also covers a first shift already above the target.
- R7: While done_o is high, ts_o follows target_ts_i with one cycle of latency.
- R8: A warning sampled in RAMP or RUN that does not fault lowers ts_o by 2(k+1) on the next cycle, where k is the decrement code. It clears done_o and restarts the ramp interval from that cycle.
- R9: A warning sampled in RAMP or RUN faults in two cases: when ts_o is at or below TS_MIN plus the decrement, or when the warning would be occurrence number (q+1) since idle, where q is the limit code. In the fault state fault_o is high, ts_o is 0, and the enables and done_o are low.
- R10: fault_o stays high while start is high. Start sampled low returns the block to IDLE on the next cycle, with all outputs low, from any state.
- R11: The warning occurrence count is cleared in IDLE, so a restarted run recovers from warnings again.
- R12: Warnings sampled during the safe-start states have no effect on the pulses or on ts_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per time-shift unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, level sensitive |
| acp_warn_i | input | 1 | Capacitive-mode warning, one pulse per event |
| target_ts_i | input | TS_W | Regulation time shift to ramp toward |
| cfg_on_code_i | input | 4 | First high-side on-time code |
| cfg_ts_code_i | input | 4 | First low-side time-shift code |
| cfg_dead_code_i | input | 2 | Dead-time code |
| cfg_step_code_i | input | 3 | Ramp step code |
| cfg_dec_code_i | input | 3 | Recovery decrement code |
| cfg_occ_code_i | input | 3 | Warning occurrence limit code |
| ts_o | output | TS_W | Time-shift value |
| gate_hs_o | output | 1 | High-side gate enable |
| gate_ls_o | output | 1 | Low-side gate enable |
| done_o | output | 1 | Soft-start complete |
| fault_o | output | 1 | Capacitive-mode fault |

## Verification
Every output comes straight from the state and time-shift registers, so a change at an input shows one clock edge later. The bench drives inputs at the falling edge and samples at the following falling edge. Taking start high at a falling edge puts the first high-side cycle after the next rising edge, which is cycle 1. RAMP is entered at cycle T_on+2·T_dead+T_fs+1, and steps follow every STEP_INTERVAL cycles from there. The safe-start and ramp tasks compute the expected enables, ts_o and done_o for each cycle index from the requirement formulas. They compare every cycle, so any output that comes a cycle early or late is reported. Warnings, target changes and start release are each checked exactly one sample after the input is applied.

// File: rtl/llc_ss_pkg.sv
package llc_ss_pkg;

    localparam int DUR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HS_ON,
        ST_DEAD_A,
        ST_LS_ON,
        ST_DEAD_B,
        ST_RAMP,
        ST_RUN,
        ST_FAULT
    } ss_state_e;

    // high-side first on-time in ticks: 8..40 by 4, then 48..96 by 8
    function automatic logic [DUR_W-1:0] hs_on_ticks(input logic [3:0] code);
        int v;
        v = (code < 4'd9) ? 8 + 4 * int'(code) : 40 + 8 * (int'(code) - 8);
        return DUR_W'(v);
    endfunction

    // first low-side time shift in ticks: 10..26 by 2, then 30..54 by 4
    function automatic logic [DUR_W-1:0] first_shift_ticks(input logic [3:0] code);
        int v;
        v = (code < 4'd9) ? 10 + 2 * int'(code) : 26 + 4 * (int'(code) - 8);
        return DUR_W'(v);
    endfunction

    // dead time in ticks: 16, 20, 24, 28
    function automatic logic [DUR_W-1:0] dead_ticks(input logic [1:0] code);
        return DUR_W'(16 + 4 * int'(code));
    endfunction

endpackage

// File: rtl/llc_ss_cfg_decode.sv
module llc_ss_cfg_decode
    import llc_ss_pkg::*;
#(
    parameter int TS_W = 12
) (
    input  logic [3:0]       on_code,
    input  logic [3:0]       ts_code,
    input  logic [1:0]       dead_code,
    input  logic [2:0]       step_code,
    input  logic [2:0]       dec_code,
    input  logic [2:0]       occ_code,
    output logic [DUR_W-1:0] on_len,
    output logic [DUR_W-1:0] first_len,
    output logic [DUR_W-1:0] dead_len,
    output logic [TS_W-1:0]  step_ts,
    output logic [TS_W-1:0]  dec_ts,
    output logic [3:0]       occ_limit
);

    always_comb begin
        on_len    = hs_on_ticks(on_code);
        first_len = first_shift_ticks(ts_code);
        dead_len  = dead_ticks(dead_code);
        step_ts   = TS_W'(int'(step_code) + 1);
        dec_ts    = TS_W'(2 * (int'(dec_code) + 1));
        occ_limit = 4'(int'(occ_code) + 1);
    end

endmodule

// File: rtl/llc_ss_interval.sv
module llc_ss_interval #(
    parameter int INTERVAL = 1800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);

    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && !clr && (cnt_q == LAST);

endmodule

// File: rtl/llc_ss_pulse_timer.sv
module llc_ss_pulse_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/llc_ss_fsm.sv
module llc_ss_fsm
    import llc_ss_pkg::*;
#(
    parameter int TS_W   = 12,
    parameter int TS_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             warn,
    input  logic [TS_W-1:0]  target,
    input  logic [DUR_W-1:0] on_len,
    input  logic [DUR_W-1:0] first_len,
    input  logic [DUR_W-1:0] dead_len,
    input  logic [TS_W-1:0]  step_ts,
    input  logic [TS_W-1:0]  dec_ts,
    input  logic [3:0]       occ_limit,
    input  logic             tick,
    input  logic             expired,
    output logic             tmr_load,
    output logic [DUR_W-1:0] tmr_val,
    output logic             ramp_en,
    output logic             restart,
    output logic [TS_W-1:0]  ts_out,
    output logic             gate_hs,
    output logic             gate_ls,
    output logic             done,
    output logic             fault
);

    ss_state_e       state_q, state_d;
    logic [TS_W-1:0] ts_q, ts_d;
    logic [3:0]      occ_q, occ_d;

    logic [TS_W:0]   ramp_sum;
    logic [TS_W:0]   floor_lvl;
    logic            at_limit;
    logic            at_floor;
    logic            trip;

    assign ramp_sum  = {1'b0, ts_q} + {1'b0, step_ts};
    assign floor_lvl = (TS_W+1)'(TS_MIN) + {1'b0, dec_ts};
    assign at_limit  = ({1'b0, occ_q} + 5'd1) >= {1'b0, occ_limit};
    assign at_floor  = {1'b0, ts_q} <= floor_lvl;
    assign trip      = at_limit || at_floor;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ts_q    <= '0;
            occ_q   <= '0;
        end else begin
            state_q <= state_d;
            ts_q    <= ts_d;
            occ_q   <= occ_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        ts_d     = ts_q;
        occ_d    = occ_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        restart  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ts_d  = '0;
                occ_d = '0;
                if (start) begin
                    state_d  = ST_HS_ON;
                    ts_d     = TS_W'(first_len);
                    tmr_load = 1'b1;
                    tmr_val  = on_len - 1'b1;
                end
            end
            ST_HS_ON: begin
                if (expired) begin
                    state_d  = ST_DEAD_A;
                    tmr_load = 1'b1;
                    tmr_val  = dead_len - 1'b1;
                end
            end
            ST_DEAD_A: begin
                if (expired) begin
                    state_d  = ST_LS_ON;
                    tmr_load = 1'b1;
                    tmr_val  = first_len - 1'b1;
                end
            end
            ST_LS_ON: begin
                if (expired) begin
                    state_d  = ST_DEAD_B;
                    tmr_load = 1'b1;
                    tmr_val  = dead_len - 1'b1;
                end
            end
            ST_DEAD_B: begin
                if (expired) begin
                    state_d = ST_RAMP;
                end
            end
            ST_RAMP: begin
                if (warn) begin
                    if (trip) begin
                        state_d = ST_FAULT;
                    end else begin
                        ts_d    = ts_q - dec_ts;
                        occ_d   = occ_q + 1'b1;
                        restart = 1'b1;
                    end
                end else if (ts_q >= target) begin
                    state_d = ST_RUN;
                    ts_d    = target;
                end else if (tick) begin
                    ts_d = (ramp_sum >= {1'b0, target}) ? target : ramp_sum[TS_W-1:0];
                end
            end
            ST_RUN: begin
                if (warn) begin
                    if (trip) begin
                        state_d = ST_FAULT;
                    end else begin
                        state_d = ST_RAMP;
                        ts_d    = ts_q - dec_ts;
                        occ_d   = occ_q + 1'b1;
                        restart = 1'b1;
                    end
                end else begin
                    ts_d = target;
                end
            end
            ST_FAULT: begin
                state_d = ST_FAULT;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (!start) begin
            state_d  = ST_IDLE;
            ts_d     = '0;
            occ_d    = '0;
            tmr_load = 1'b0;
            restart  = 1'b0;
        end
    end

    // outputs
    always_comb begin
        ramp_en = (state_q == ST_RAMP);
        gate_hs = (state_q == ST_HS_ON);
        gate_ls = (state_q == ST_LS_ON);
        done    = (state_q == ST_RUN);
        fault   = (state_q == ST_FAULT);
        ts_out  = (state_q == ST_IDLE || state_q == ST_FAULT) ? '0 : ts_q;
    end

endmodule

// File: rtl/llc_ss_seq.sv
module llc_ss_seq
    import llc_ss_pkg::*;
#(
    parameter int TS_W          = 12,
    parameter int STEP_INTERVAL = 1800,
    parameter int TS_MIN        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            acp_warn_i,
    input  logic [TS_W-1:0] target_ts_i,
    input  logic [3:0]      cfg_on_code_i,
    input  logic [3:0]      cfg_ts_code_i,
    input  logic [1:0]      cfg_dead_code_i,
    input  logic [2:0]      cfg_step_code_i,
    input  logic [2:0]      cfg_dec_code_i,
    input  logic [2:0]      cfg_occ_code_i,
    output logic [TS_W-1:0] ts_o,
    output logic            gate_hs_o,
    output logic            gate_ls_o,
    output logic            done_o,
    output logic            fault_o
);

    logic [DUR_W-1:0] on_len, first_len, dead_len, tmr_val;
    logic [TS_W-1:0]  step_ts, dec_ts;
    logic [3:0]       occ_limit;
    logic             tick, expired, tmr_load, ramp_en, restart;

    llc_ss_cfg_decode #(.TS_W(TS_W)) dec_i (
        .on_code   (cfg_on_code_i),
        .ts_code   (cfg_ts_code_i),
        .dead_code (cfg_dead_code_i),
        .step_code (cfg_step_code_i),
        .dec_code  (cfg_dec_code_i),
        .occ_code  (cfg_occ_code_i),
        .on_len    (on_len),
        .first_len (first_len),
        .dead_len  (dead_len),
        .step_ts   (step_ts),
        .dec_ts    (dec_ts),
        .occ_limit (occ_limit)
    );

    llc_ss_interval #(.INTERVAL(STEP_INTERVAL)) ivl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ramp_en),
        .clr   (restart),
        .tick  (tick)
    );

    llc_ss_pulse_timer #(.W(DUR_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    llc_ss_fsm #(.TS_W(TS_W), .TS_MIN(TS_MIN)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .warn      (acp_warn_i),
        .target    (target_ts_i),
        .on_len    (on_len),
        .first_len (first_len),
        .dead_len  (dead_len),
        .step_ts   (step_ts),
        .dec_ts    (dec_ts),
        .occ_limit (occ_limit),
        .tick      (tick),
        .expired   (expired),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .ramp_en   (ramp_en),
        .restart   (restart),
        .ts_out    (ts_o),
        .gate_hs   (gate_hs_o),
        .gate_ls   (gate_ls_o),
        .done      (done_o),
        .fault     (fault_o)
    );

endmodule

// File: rtl/llc_ss_seq_chk.sv
module llc_ss_seq_chk #(
    parameter int TS_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            acp_warn_i,
    input logic [TS_W-1:0] target_ts_i,
    input logic [TS_W-1:0] ts_o,
    input logic            gate_hs_o,
    input logic            gate_ls_o,
    input logic            done_o,
    input logic            fault_o
);

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hs_o && gate_ls_o));

    a_r3_gap_before_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ls_o) |-> !$past(gate_hs_o));

    a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (ts_o == '0 && !gate_hs_o && !gate_ls_o && !done_o));

    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (ts_o == '0 && !done_o && !fault_o && !gate_hs_o && !gate_ls_o));

    a_r7_done_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ts_o == $past(target_ts_i));

    a_r5_no_drop_without_warn: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_o != '0 && $past(ts_o) != '0 && !done_o && !$past(acp_warn_i))
        |-> ts_o >= $past(ts_o));

endmodule

bind llc_ss_seq llc_ss_seq_chk #(.TS_W(TS_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .acp_warn_i  (acp_warn_i),
    .target_ts_i (target_ts_i),
    .ts_o        (ts_o),
    .gate_hs_o   (gate_hs_o),
    .gate_ls_o   (gate_ls_o),
    .done_o      (done_o),
    .fault_o     (fault_o)
);

// File: tb/llc_ss_seq_tb_top.sv
`timescale 1ns/1ps
module llc_ss_seq_tb_top;

    localparam int TS_W = 12;
    localparam int IVL  = 16;
    localparam int TMIN = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            acp_warn_i = 1'b0;
    logic [TS_W-1:0] target_ts_i = '0;
    logic [3:0]      cfg_on_code_i = '0;
    logic [3:0]      cfg_ts_code_i = '0;
    logic [1:0]      cfg_dead_code_i = '0;
    logic [2:0]      cfg_step_code_i = '0;
    logic [2:0]      cfg_dec_code_i = '0;
    logic [2:0]      cfg_occ_code_i = '0;
    logic [TS_W-1:0] ts_o;
    logic            gate_hs_o, gate_ls_o, done_o, fault_o;

    int n_checks = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    llc_ss_seq #(.TS_W(TS_W), .STEP_INTERVAL(IVL), .TS_MIN(TMIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .acp_warn_i(acp_warn_i),
        .target_ts_i(target_ts_i), .cfg_on_code_i(cfg_on_code_i),
        .cfg_ts_code_i(cfg_ts_code_i), .cfg_dead_code_i(cfg_dead_code_i),
        .cfg_step_code_i(cfg_step_code_i), .cfg_dec_code_i(cfg_dec_code_i),
        .cfg_occ_code_i(cfg_occ_code_i), .ts_o(ts_o), .gate_hs_o(gate_hs_o),
        .gate_ls_o(gate_ls_o), .done_o(done_o), .fault_o(fault_o)
    );

    function automatic int f_on(input int c);
        return (c < 9) ? 8 + 4 * c : 40 + 8 * (c - 8);
    endfunction
    function automatic int f_fs(input int c);
        return (c < 9) ? 10 + 2 * c : 26 + 4 * (c - 8);
    endfunction
    function automatic int f_dt(input int c);
        return 16 + 4 * c;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_warn();
        acp_warn_i = 1'b1;
        @(negedge clk);
        acp_warn_i = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1 ts after reset", int'(ts_o), 0);
        chk("R1 high-side after reset", int'(gate_hs_o), 0);
        chk("R1 low-side after reset", int'(gate_ls_o), 0);
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 fault after reset", int'(fault_o), 0);
    endtask

    // starts from a falling edge with start low; ends at the sample of RAMP entry
    task automatic t_safe_start(input int on_c, input int fs_c, input int dt_c, input bit warn_mid);
        int on_t, fs_t, dt_t, k;
        int m_hs, m_ls, m_ts, m_dead, m_ov;
        on_t = f_on(on_c); fs_t = f_fs(fs_c); dt_t = f_dt(dt_c);
        k = on_t + 2 * dt_t + fs_t + 1;
        m_hs = 0; m_ls = 0; m_ts = 0; m_dead = 0; m_ov = 0;
        cfg_on_code_i = 4'(on_c); cfg_ts_code_i = 4'(fs_c); cfg_dead_code_i = 2'(dt_c);
        start_i = 1'b1;
        for (int i = 1; i < k; i++) begin
            bit e_hs, e_ls;
            @(negedge clk);
            acp_warn_i = warn_mid && (i == 3);
            e_hs = (i <= on_t);
            e_ls = (i > on_t + dt_t) && (i <= on_t + dt_t + fs_t);
            if (gate_hs_o !== e_hs) m_hs++;
            if (gate_ls_o !== e_ls) m_ls++;
            if (int'(ts_o) != fs_t) m_ts++;
            if (!e_hs && !e_ls && (gate_hs_o || gate_ls_o)) m_dead++;
            if (gate_hs_o && gate_ls_o) m_ov++;
        end
        @(negedge clk);
        acp_warn_i = 1'b0;
        chk("R2 high-side pulse cycles mismatched", m_hs, 0);
        chk("R3 dead-time cycles with a gate high", m_dead + m_ov, 0);
        chk("R4 low-side pulse cycles mismatched", m_ls, 0);
        chk("R4 ts held at first shift mismatches", m_ts, 0);
        if (warn_mid) chk("R12 safe-start disturbed by warning", m_hs + m_ls + m_ts + m_dead, 0);
    endtask

    // sample index 0 is the current falling edge, the first cycle of RAMP
    task automatic t_ramp(input string tag, input int first, input int tgt, input int step, input int n);
        int m_ts, m_done, e_ts;
        bit reached;
        m_ts = 0; m_done = 0; reached = 0;
        for (int j = 0; j < n; j++) begin
            if (j == 0) e_ts = first;
            else begin
                e_ts = first + (j / IVL) * step;
                if (e_ts > tgt) e_ts = tgt;
            end
            if (int'(ts_o) != e_ts) m_ts++;
            if (done_o !== reached) m_done++;
            if (e_ts >= tgt) reached = 1;
            @(negedge clk);
        end
        chk({tag, " R5 ramp trajectory mismatches"}, m_ts, 0);
        chk({tag, " R6 done timing mismatches"}, m_done, 0);
    endtask

    task automatic t_follow_and_recover();
        target_ts_i = 12'd55;
        @(negedge clk);
        chk("R7 ts follows new target", int'(ts_o), 55);
        chk("R7 done stays high", int'(done_o), 1);
        pulse_warn();
        chk("R8 ts reduced by decrement", int'(ts_o), 51);
        chk("R8 done cleared on recovery", int'(done_o), 0);
        t_ramp("R8 resumed", 51, 55, 3, 3 * IVL + 4);
    endtask

    task automatic t_stop();
        start_i = 1'b0;
        @(negedge clk);
        chk("R10 ts zero after stop", int'(ts_o), 0);
        chk("R10 done low after stop", int'(done_o), 0);
    endtask

    task automatic t_occ_fault();
        pulse_warn();
        chk("R8 first warning recovers ts", int'(ts_o), 28);
        chk("R8 first warning no fault", int'(fault_o), 0);
        pulse_warn();
        chk("R9 limit reached raises fault", int'(fault_o), 1);
        chk("R9 ts zero in fault", int'(ts_o), 0);
        chk("R9 gates low in fault", int'(gate_hs_o) + int'(gate_ls_o) + int'(done_o), 0);
        repeat (20) @(negedge clk);
        chk("R10 fault held while start high", int'(fault_o), 1);
        start_i = 1'b0;
        @(negedge clk);
        chk("R10 fault cleared after stop", int'(fault_o), 0);
    endtask

    task automatic t_rerun_clears_count();
        t_safe_start(12, 13, 3, 1'b0);
        t_ramp("R11 rerun", 46, 30, 8, 4);
        pulse_warn();
        chk("R11 count cleared, warning recovers", int'(fault_o), 0);
        chk("R11 ts after recovery", int'(ts_o), 28);
        t_stop();
    endtask

    task automatic t_floor_fault();
        cfg_step_code_i = 3'd0; cfg_dec_code_i = 3'd3; cfg_occ_code_i = 3'd7;
        target_ts_i = 12'd14;
        t_safe_start(0, 0, 0, 1'b0);
        t_ramp("S4", 10, 14, 1, 70);
        pulse_warn();
        chk("R9 floor reached raises fault", int'(fault_o), 1);
        t_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();

        cfg_step_code_i = 3'd2; cfg_dec_code_i = 3'd1; cfg_occ_code_i = 3'd7;
        target_ts_i = 12'd40;
        t_safe_start(0, 0, 0, 1'b0);
        t_ramp("S1", 10, 40, 3, 200);
        t_follow_and_recover();
        t_stop();

        cfg_step_code_i = 3'd7; cfg_dec_code_i = 3'd0; cfg_occ_code_i = 3'd1;
        target_ts_i = 12'd30;
        t_safe_start(12, 13, 3, 1'b1);
        t_ramp("R6 above target", 46, 30, 8, 6);
        t_occ_fault();

        t_rerun_clears_count();
        t_floor_fault();

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule